// File: doc/BRIEF.md
# SDRAM Read-Interrupt Turnaround Sequencer

This block drives the command, byte-mask and data lines of a single-data-rate SDRAM for four-beat bursts. A client presents one request at a time, a read or a write carrying four data words, and the sequencer turns it into a READ or WRITE command. A new read may cut short a read burst that is still running; the newer burst's data then takes over the bus. A write may also cut short a read. To allow this, the sequencer raises the byte mask early so that the remaining read beats never reach the pins. It then waits for a bus-idle cycle before it turns on its own drivers.

Read beats that arrive unmasked are registered and passed to the client together with their position inside the burst. CAS latency is chosen with a configuration input (2 or 3 clocks). The attached memory is taken to mask a read beat with the mask value it sampled two clocks earlier. It is also taken to drop any beat of an interrupted read that would reach the pins two or more cycles after a WRITE command. Row activation, refresh and precharge are handled elsewhere.

Top module: `rdwr_turn_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, cmd_o is NOP (2'b00), dqm_o, dq_oe and rd_valid are low, and req_ready is high.
- R2: cmd_o is 2'b01 (READ) in a cycle where req_valid and req_ready are high and req_write is low, 2'b10 (WRITE) when req_write is high, and 2'b00 (NOP) otherwise; 2'b11 never appears.
- R3: A read beat i (0..3) of a READ issued in cycle r is on dq_in in cycle r+CL, where CL is 3 when cas_lat3 is high and 2 otherwise. When unmasked, it shows on rd_data with rd_beat = i and rd_valid high in cycle r+CL+1.
- R4: A READ is accepted in any cycle after an earlier READ. Beats of the older burst that would arrive at or after the new burst's first beat are replaced by the new burst, so the client sees the newer beats starting at index 0.
- R5: dqm_o is high exactly in the cycles where a write request is waiting (req_valid and req_write high, req_ready low) and no write burst is on the bus.
- R6: A WRITE is issued only in a cycle w such that no unmasked read beat was on the bus in cycle w-1 and every read beat due in cycles w and w+1 is masked. With a read issued at r and a write requested at r+d, the WRITE lands at r+4 for CL 2 with d=1, at r+1 for CL 3 with d=1, and at r+5 for CL 3 with d=2.
- R7: dq_oe is never high in a cycle in which the memory drives an unmasked read beat.
- R8: dq_oe is high for exactly four cycles starting in the WRITE cycle. dq_out carries req_wdata[DW*i +: DW] in the i-th of them, and req_ready stays low in the three cycles after the WRITE.
- R9: A read beat that was masked, or that was dropped by a write, never raises rd_valid. A write requested one cycle after a CL 2 read returns one beat; in the CL 3 cases of R6 it returns none (d=1) or one (d=2).
- R10: A write request with no read beat pending and no write burst running is accepted in the cycle it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat3 | input | 1 | High selects CAS latency 3, low selects 2 |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | High for write, low for read |
| req_wdata | input | BEATS*DW | Write words, beat i in bits DW*i +: DW |
| req_ready | output | 1 | Request accepted this cycle when valid |
| cmd_o | output | 2 | 00 NOP, 01 READ, 10 WRITE |
| dqm_o | output | 1 | Byte mask to the memory |
| dq_oe | output | 1 | Enable of the controller's data drivers |
| dq_out | output | DW | Write data to the bus |
| dq_in | input | DW | Data from the bus |
| rd_valid | output | 1 | Captured read beat valid |
| rd_data | output | DW | Captured read beat |
| rd_beat | output | $clog2(BEATS) | Index of the captured beat in its burst |

## Verification
The assertions take for granted that cas_lat3 changes only while no burst is in flight. They also assume that a waiting request keeps its type and data until it is accepted. The mask-history check further assumes that dq_in carries a beat only in the cycles the sequencer's own schedule predicts. The stimulus changes the latency setting only after long idle stretches and holds every write request until req_ready rises. A bench memory model follows the same burst, mask-latency and write-termination rules when it drives dq_in.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10
  } cmd_e;

  localparam int MASK_LAT = 2;
  localparam int CL_LO    = 2;
  localparam int CL_HI    = 3;
endpackage

// File: rtl/rts_beat_track.sv
module rts_beat_track
  import rts_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cl3,
  input  logic                      rd_go,
  input  logic                      wr_go,
  input  logic                      dqm,
  output logic                      drv_now,
  output logic                      drv_next,
  output logic                      drv_prev,
  output logic [$clog2(BEATS)-1:0]  beat_idx
);
  localparam int DEPTH = CL_HI + BEATS;
  localparam int BW    = $clog2(BEATS);

  logic [DEPTH-1:0] occ_q, msk_q, occ_d, msk_d, occ_c, msk_c;
  logic [BW-1:0]    idx_q [DEPTH];
  logic [BW-1:0]    idx_d [DEPTH];
  logic [BW-1:0]    idx_c [DEPTH];
  logic             prev_q;
  int               cl_c;

  // insert new burst, cancel on write, apply mask, then shift one slot
  always_comb begin
    cl_c  = cl3 ? CL_HI : CL_LO;
    occ_c = occ_q;
    msk_c = msk_q;
    for (int k = 0; k < DEPTH; k++) begin
      idx_c[k] = idx_q[k];
      if (rd_go && k >= cl_c) begin
        if (k < cl_c + BEATS) begin
          occ_c[k] = 1'b1;
          msk_c[k] = 1'b0;
          idx_c[k] = BW'(k - cl_c);
        end else begin
          occ_c[k] = 1'b0;
        end
      end
      if (wr_go && k >= MASK_LAT) occ_c[k] = 1'b0;
    end
    if (dqm) msk_c[MASK_LAT] = 1'b1;
    occ_d = {1'b0, occ_c[DEPTH-1:1]};
    msk_d = {1'b0, msk_c[DEPTH-1:1]};
    for (int k = 0; k < DEPTH - 1; k++) idx_d[k] = idx_c[k+1];
    idx_d[DEPTH-1] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      msk_q  <= '0;
      prev_q <= 1'b0;
      for (int k = 0; k < DEPTH; k++) idx_q[k] <= '0;
    end else begin
      occ_q  <= occ_d;
      msk_q  <= msk_d;
      prev_q <= drv_now;
      for (int k = 0; k < DEPTH; k++) idx_q[k] <= idx_d[k];
    end
  end

  assign drv_now  = occ_q[0] & ~msk_q[0];
  assign drv_next = occ_q[1] & ~msk_q[1];
  assign drv_prev = prev_q;
  assign beat_idx = idx_q[0];

  // R9: a beat on the pins unmasked saw a low mask two cycles before
  p_unmasked_hist_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drv_now |-> !$past(dqm, 2));

  // R9: after a write only the two committed slots may still hold beats
  p_write_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> (occ_q[DEPTH-1:1] == '0));
endmodule

// File: rtl/rts_wr_drive.sv
module rts_wr_drive #(
  parameter int DW    = 16,
  parameter int BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [BEATS*DW-1:0] wdata,
  output logic              busy,
  output logic              oe,
  output logic [DW-1:0]     dout
);
  localparam int BW = $clog2(BEATS);

  logic [BEATS*DW-1:0] buf_q;
  logic [BW-1:0]       ptr_q, ptr_d;
  logic                act_q, act_d;

  always_comb begin
    ptr_d = ptr_q;
    act_d = act_q;
    if (wr_go) begin
      ptr_d = BW'(1);
      act_d = (BEATS > 1);
    end else if (act_q) begin
      if (ptr_q == BW'(BEATS - 1)) act_d = 1'b0;
      else                         ptr_d = ptr_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      act_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     buf_q <= '0;
    else if (wr_go) buf_q <= wdata;
  end

  assign busy = act_q;
  assign oe   = wr_go | act_q;
  assign dout = wr_go ? wdata[DW-1:0] : (act_q ? buf_q[ptr_q*DW +: DW] : '0);

  // R8: a started write burst keeps the drivers on in the next cycle
  p_burst_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |=> oe);
endmodule

// File: rtl/rts_rd_cap.sv
module rts_rd_cap #(
  parameter int DW = 16,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_on,
  input  logic [BW-1:0] beat_idx,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [BW-1:0] rd_beat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= beat_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_beat <= '0;
    end else if (beat_on) begin
      rd_data <= dq_in;
      rd_beat <= beat_idx;
    end
  end
endmodule

// File: rtl/rdwr_turn_seq.sv
module rdwr_turn_seq
  import rts_pkg::*;
#(
  parameter int DW    = 16,
  parameter int BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cas_lat3,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [BEATS*DW-1:0]       req_wdata,
  output logic                      req_ready,
  output logic [1:0]                cmd_o,
  output logic                      dqm_o,
  output logic                      dq_oe,
  output logic [DW-1:0]             dq_out,
  input  logic [DW-1:0]             dq_in,
  output logic                      rd_valid,
  output logic [DW-1:0]             rd_data,
  output logic [$clog2(BEATS)-1:0]  rd_beat
);
  localparam int BW = $clog2(BEATS);

  logic          drv_now, drv_next, drv_prev;
  logic [BW-1:0] beat_idx;
  logic          wr_busy, wr_ok, rd_go, wr_go;
  cmd_e          cmd_c;

  // write may start: bus idle last cycle, nothing unmasked now or next
  assign wr_ok     = ~wr_busy & ~drv_prev & ~drv_now & ~drv_next;
  assign req_ready = ~wr_busy & (~req_write | wr_ok);
  assign rd_go     = req_valid & req_ready & ~req_write;
  assign wr_go     = req_valid & req_ready &  req_write;
  assign dqm_o     = req_valid & req_write & ~req_ready & ~wr_busy;

  always_comb begin
    cmd_c = CMD_NOP;
    if (rd_go)      cmd_c = CMD_RD;
    else if (wr_go) cmd_c = CMD_WR;
  end
  assign cmd_o = cmd_c;

  rts_beat_track #(.BEATS(BEATS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .cl3      (cas_lat3),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .dqm      (dqm_o),
    .drv_now  (drv_now),
    .drv_next (drv_next),
    .drv_prev (drv_prev),
    .beat_idx (beat_idx)
  );

  rts_wr_drive #(.DW(DW), .BEATS(BEATS)) u_wr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_go (wr_go),
    .wdata (req_wdata),
    .busy  (wr_busy),
    .oe    (dq_oe),
    .dout  (dq_out)
  );

  rts_rd_cap #(.DW(DW), .BW(BW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_on  (drv_now),
    .beat_idx (beat_idx),
    .dq_in    (dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_beat  (rd_beat)
  );

  p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !drv_now);

  p_idle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> !drv_prev);

  p_mask_off_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dqm_o);

  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o != 2'b11);

  p_capture_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(dqm_o, 3));
endmodule

// File: tb/rdwr_turn_seq_test.sv
module rdwr_turn_seq_test;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int BEATS = 4;
  localparam int NS    = 256;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 cas_lat3;
  logic                 req_valid, req_write;
  logic [BEATS*DW-1:0]  req_wdata;
  logic                 req_ready;
  logic [1:0]           cmd_o;
  logic                 dqm_o, dq_oe;
  logic [DW-1:0]        dq_out, dq_in;
  logic                 rd_valid;
  logic [DW-1:0]        rd_data;
  logic [1:0]           rd_beat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  rdwr_turn_seq #(.DW(DW), .BEATS(BEATS)) uut (
    .clk(clk), .rst_n(rst_n), .cas_lat3(cas_lat3),
    .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .cmd_o(cmd_o), .dqm_o(dqm_o), .dq_oe(dq_oe),
    .dq_out(dq_out), .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_beat(rd_beat)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  bit            m_occ [NS];
  bit            m_msk [NS];
  logic [DW-1:0] m_dat [NS];
  int            m_idx [NS];
  int            mc = 0;
  int            rdno = 0;
  int            wr_k = 99;
  logic [BEATS*DW-1:0] wexp;
  bit            sd_drive = 1'b0;
  bit            drv_prev = 1'b0, oe_prev = 1'b0;
  logic [DW-1:0] prev_dat;
  int            prev_idx;

  always begin
    @(negedge clk);
    #(CLK_P/2 - 1);
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_occ[i] = 0; m_msk[i] = 0; end
      wr_k = 99;
    end else begin
      if (cmd_o == 2'b01) begin
        int cl;
        cl = cas_lat3 ? 3 : 2;
        rdno++;
        for (int i = 0; i < BEATS; i++) begin
          m_occ[(mc+cl+i)%NS] = 1; m_msk[(mc+cl+i)%NS] = 0;
          m_dat[(mc+cl+i)%NS] = {8'(rdno), 8'(i)};
          m_idx[(mc+cl+i)%NS] = i;
        end
        for (int i = BEATS; i < BEATS+4; i++) m_occ[(mc+cl+i)%NS] = 0;
      end
      if (cmd_o == 2'b10) begin
        for (int j = 2; j < 12; j++) m_occ[(mc+j)%NS] = 0;
        wr_k = 0;
        wexp = req_wdata;
      end
      if (dqm_o) m_msk[(mc+2)%NS] = 1;
      if (dq_oe) begin
        chk(!sd_drive, "R7 bus contention", dq_oe, 0);
        chk(wr_k < BEATS, "R8 drivers on too long", wr_k, BEATS-1);
        if (wr_k < BEATS) chk(dq_out == wexp[wr_k*DW +: DW], "R8 write word", dq_out, wexp[wr_k*DW +: DW]);
        if (!oe_prev) chk(!drv_prev, "R6 no idle gap", drv_prev, 0);
      end
      if (rd_valid || drv_prev) begin
        chk(rd_valid == drv_prev, rd_valid ? "R9 masked beat captured" : "R3 beat missed", rd_valid, drv_prev);
        if (rd_valid && drv_prev) begin
          chk(rd_data == prev_dat, "R3 read data", rd_data, prev_dat);
          chk(int'(rd_beat) == prev_idx, "R3 beat index", rd_beat, prev_idx);
        end
      end
      if (wr_k < 99) wr_k++;
    end
    oe_prev  = dq_oe;
    drv_prev = sd_drive;
    prev_dat = m_dat[mc%NS];
    prev_idx = m_idx[mc%NS];
    m_occ[mc%NS] = 0;
    m_msk[mc%NS] = 0;
    @(posedge clk);
    #1;
    mc++;
    sd_drive = rst_n && m_occ[mc%NS] && !m_msk[mc%NS];
    dq_in    = sd_drive ? m_dat[mc%NS] : 16'hDEAD;
  end

  // ---------------- scenarios ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_write = 0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cmd_o == 2'b00, "R1 cmd in reset", cmd_o, 0);
    chk(!dqm_o && !dq_oe, "R1 mask/oe in reset", {dqm_o, dq_oe}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_valid, "R1 rd_valid after reset", rd_valid, 0);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(cmd_o == 2'b00 && !dqm_o && !dq_oe, "R1 quiet after reset", {cmd_o, dqm_o, dq_oe}, 0);
  endtask

  task automatic t_read_plain(input bit c3);
    int n;
    cas_lat3 = c3;
    idle(2);
    @(negedge clk);
    req_valid = 1; req_write = 0;
    #1 chk(cmd_o == 2'b01, "R2 READ code", cmd_o, 1);
    n = 0;
    do begin
      @(negedge clk);
      req_valid = 0;
      n++;
    end while (!rd_valid && n < 10);
    chk(n == (c3 ? 4 : 3), "R3 first beat latency", n, c3 ? 4 : 3);
    chk(rd_beat == 0, "R3 first beat index", rd_beat, 0);
    for (int i = 1; i < BEATS; i++) begin
      @(negedge clk);
      chk(rd_valid && rd_beat == 2'(i), "R3 beat order", {rd_valid, rd_beat}, {1'b1, 2'(i)});
    end
    idle(8);
  endtask

  task automatic t_rd_rd(input bit c3);
    int cnt;
    int bseq[8];
    logic [7:0] tg[8];
    cas_lat3 = c3;
    idle(2);
    cnt = 0;
    @(negedge clk); req_valid = 1; req_write = 0;
    @(negedge clk); req_valid = 0;
    @(negedge clk); req_valid = 1;
    #1 chk(req_ready && cmd_o == 2'b01, "R4 interrupting READ accepted", {req_ready, cmd_o}, 3'b101);
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (rd_valid && cnt < 8) begin bseq[cnt] = rd_beat; tg[cnt] = rd_data[15:8]; cnt++; end
    end
    chk(cnt == 6, "R4 beats seen", cnt, 6);
    chk(bseq[0]==0 && bseq[1]==1 && bseq[2]==0 && bseq[3]==1 && bseq[4]==2 && bseq[5]==3,
        "R4 beat sequence", {bseq[2], bseq[3]}, {32'd0, 32'd1});
    chk(tg[0] == tg[1] && tg[2] != tg[1] && tg[2] == tg[5], "R4 newer burst takes over", tg[2], tg[1] + 1);
    idle(6);
  endtask

  task automatic t_wr_idle();
    cas_lat3 = 0;
    idle(3);
    @(negedge clk);
    req_valid = 1; req_write = 1;
    req_wdata = {16'hC303, 16'hC202, 16'hC101, 16'hC000};
    #1;
    chk(req_ready, "R10 write accepted at once", req_ready, 1);
    chk(cmd_o == 2'b10, "R2 WRITE code", cmd_o, 2);
    chk(dq_oe && !dqm_o, "R8 drivers on in WRITE cycle", {dq_oe, dqm_o}, 2'b10);
    for (int i = 1; i < BEATS; i++) begin
      @(negedge clk);
      req_valid = 0; req_write = 0;
      #1 chk(!req_ready && dq_oe, "R8 busy during burst", {req_ready, dq_oe}, 2'b01);
    end
    @(negedge clk);
    #1 chk(req_ready && !dq_oe, "R8 burst over after four", {req_ready, dq_oe}, 2'b10);
    idle(4);
  endtask

  task automatic t_rd_wr(input bit c3, input int d, input int exp_w, input int exp_caps);
    int w, caps;
    cas_lat3 = c3;
    idle(3);
    w = -1; caps = 0;
    @(negedge clk); req_valid = 1; req_write = 0;
    for (int cyc = 1; cyc < 20; cyc++) begin
      @(negedge clk);
      if (rd_valid) caps++;
      if (w < 0 && cyc >= d) begin
        req_valid = 1; req_write = 1;
        req_wdata = {16'hE303, 16'hE202, 16'hE101, 16'(16'hE000 + d)};
        #1;
        if (req_ready) begin
          w = cyc;
          chk(cmd_o == 2'b10 && !dqm_o, "R2 WRITE issued", {cmd_o, dqm_o}, 3'b100);
        end else begin
          chk(dqm_o, "R5 mask while write waits", dqm_o, 1);
        end
      end else begin
        req_valid = 0; req_write = 0;
        #1;
        if (w < 0 || cyc >= w + BEATS) chk(!dqm_o, "R5 mask low without waiting write", dqm_o, 0);
      end
    end
    chk(w == exp_w, "R6 WRITE cycle", w, exp_w);
    chk(caps == exp_caps, "R9 beats returned before write", caps, exp_caps);
    idle(4);
  endtask

  initial begin
    rst_n = 0; cas_lat3 = 0; req_valid = 0; req_write = 0; req_wdata = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_read_plain(0);
    t_read_plain(1);
    t_rd_rd(0);
    t_rd_rd(1);
    t_wr_idle();
    t_rd_wr(0, 1, 4, 1);
    t_rd_wr(1, 1, 1, 0);
    t_rd_wr(1, 2, 5, 1);
    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1-all act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule